// File: doc/BRIEF.md
# Multi-method syntax element binarizer

This block turns one non-binary syntax element value into a serial string of bins ready for a binary arithmetic coder. A method code chosen with each request selects the binarization. The available methods are unary, truncated unary with a per-request cutoff, and fixed length with a per-request bit count. There is also k-th order Exp-Golomb with a per-request order, and the concatenated form, in which a truncated unary prefix is followed by an Exp-Golomb suffix. The concatenated form comes in an unsigned flavour and in a signed flavour that appends a sign bin.

A request is a one-cycle `start` pulse with the value, method, cutoff, order and length held on the inputs in that cycle. The block registers what it needs and, from the next cycle, presents one bin per clock with `bin_valid`. It raises `bin_last` together with the final bin. Motion vector differences use the signed concatenated form with cutoff 9 and order 3. Coefficient levels minus one use the unsigned form with cutoff 14 and order 0.

Top module: `se_binarizer`

## Requirements
- R1: With method code 0 (unary), a value x gives x bins of 1 followed by a single bin of 0.
- R2: With method code 1 (truncated unary) and a cutoff S of at least 1, a value below S gives its unary string, and a value at or above S gives exactly S bins of 1 with no closing 0.
- R3: With method code 2 (fixed length), the low L bits of the value are sent most significant first, where L is `fix_len`. An L larger than VAL_W is treated as VAL_W.
- R4: With method code 3 (Exp-Golomb of order k), the block first sends a 1 and subtracts 2^k from the remainder each time the remainder is at least 2^k, then increments k. It then sends a 0, followed by the k low bits of what remains, most significant first.
- R5: With method code 4, the value first gets a truncated unary prefix with the given cutoff. Only when the value is at or above the cutoff does an Exp-Golomb string of the given order follow, encoding the value minus the cutoff. A cutoff of 0 therefore leaves the Exp-Golomb string alone.
- R6: With method code 5, the value is read as two's complement. Its magnitude is binarized as in R5 and is followed by one sign bin (1 for negative, 0 for positive) only when the magnitude is nonzero.
- R7: The first bin of a string is valid in the cycle after `start` is accepted. The bins follow with `bin_valid` high on every cycle until the last one. `bin_last` is high only with the final bin, and `bin_valid` is low in the cycle after it.
- R8: A `start` seen while `bin_valid` is high, including the cycle of the last bin, is ignored: the current string is unchanged and no new string follows.
- R9: A request whose string would be empty (fixed length with `fix_len` 0, or truncated unary with cutoff 0) and a request with reserved method codes 6 or 7 produce no bins, and the block stays idle.
- R10: During and straight after reset, `bin_valid` and `bin_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| method | input | 3 | Binarization method code |
| value | input | VAL_W | Syntax element value (two's complement for code 5) |
| cutoff | input | CUT_W | Truncated unary cutoff |
| order | input | K_W | Exp-Golomb starting order |
| fix_len | input | LEN_W | Fixed-length bin count |
| bin_valid | output | 1 | A bin is present this cycle |
| bin_bit | output | 1 | Bin value |
| bin_last | output | 1 | Present bin ends the string |

## Verification
The checker watches the framing of the stream on every cycle. A string opens only after a start, it has no holes, it closes the cycle after `bin_last`, and a start during the final bin launches nothing. It also tracks the shape of the simple methods: unary strings are ones closed by a zero, a truncated unary string never runs past its cutoff, and requests for reserved codes or zero-length fixed fields keep the block idle. The exact bin patterns of fixed length, Exp-Golomb, the concatenated forms and the sign placement only show up in the bench. The bench compares whole strings against hand-worked expectations, with values below, at and above the cutoff, cutoff 0, negative and zero signed values, and length clamping.

// File: rtl/se_bin_pkg.sv
package se_bin_pkg;

   localparam logic [2:0] M_UNARY          = 3'd0;
   localparam logic [2:0] M_TRUNC          = 3'd1;
   localparam logic [2:0] M_FIXED          = 3'd2;
   localparam logic [2:0] M_EXPG           = 3'd3;
   localparam logic [2:0] M_TRUNC_EXPG     = 3'd4;
   localparam logic [2:0] M_TRUNC_EXPG_SGN = 3'd5;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ONES  = 3'd1,
      PH_TERM  = 3'd2,
      PH_EGPFX = 3'd3,
      PH_EGBIT = 3'd4,
      PH_FIX   = 3'd5,
      PH_SIGN  = 3'd6
   } phase_e;

   // segment that follows the Exp-Golomb part
   function automatic phase_e after_eg(input logic sgn);
      return sgn ? PH_SIGN : PH_IDLE;
   endfunction

   // segment that follows the closing zero of the prefix
   function automatic phase_e after_term(input logic sfx, input logic sgn);
      return sfx ? PH_EGPFX : after_eg(sgn);
   endfunction

   // segment that follows the run of prefix ones
   function automatic phase_e after_ones(input logic term, input logic sfx, input logic sgn);
      return term ? PH_TERM : after_term(sfx, sgn);
   endfunction

endpackage

// File: rtl/se_bin_front.sv
module se_bin_front
   import se_bin_pkg::*;
#(
   parameter int VAL_W     = 16,
   parameter int CUT_W     = 5,
   parameter int K_W       = 3,
   parameter int LEN_W     = 5,
   parameter int IDX_W     = 6,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [2:0]       method,
   input  logic [VAL_W-1:0] value,
   input  logic [CUT_W-1:0] cutoff,
   input  logic [K_W-1:0]   order,
   input  logic [LEN_W-1:0] fix_len,
   output logic [VAL_W-1:0] pfx_ones,
   output logic             pfx_term,
   output logic             sfx_en,
   output logic [VAL_W-1:0] sfx_val,
   output logic [IDX_W-1:0] sfx_k,
   output logic             sign_en,
   output logic             sign_bit,
   output logic             fix_en,
   output logic [IDX_W-1:0] fix_cnt,
   output logic             empty
);

   logic [VAL_W-1:0] mag;
   logic             neg;
   logic [VAL_W-1:0] cut_ext;
   logic             at_cut;
   logic [VAL_W-1:0] over_cut;

   generate
      if (SIGNED_EN) begin : g_signed
         always_comb begin
            neg = (method == M_TRUNC_EXPG_SGN) && value[VAL_W-1];
            mag = neg ? (~value + VAL_W'(1)) : value;
         end
      end else begin : g_unsigned
         assign neg = 1'b0;
         assign mag = value;
      end
   endgenerate

   assign cut_ext  = VAL_W'(cutoff);
   assign at_cut   = (mag >= cut_ext);
   assign over_cut = mag - cut_ext;

   always_comb begin
      pfx_ones = '0;
      pfx_term = 1'b0;
      sfx_en   = 1'b0;
      sfx_val  = '0;
      sfx_k    = '0;
      sign_en  = 1'b0;
      sign_bit = 1'b0;
      fix_en   = 1'b0;
      fix_cnt  = '0;
      case (method)
         M_UNARY: begin
            pfx_ones = value;
            pfx_term = 1'b1;
         end
         M_TRUNC: begin
            pfx_ones = at_cut ? cut_ext : mag;
            pfx_term = !at_cut;
         end
         M_FIXED: begin
            fix_en  = 1'b1;
            sfx_val = value;
            if (int'(fix_len) > VAL_W) fix_cnt = IDX_W'(VAL_W);
            else                       fix_cnt = IDX_W'(fix_len);
         end
         M_EXPG: begin
            sfx_en  = 1'b1;
            sfx_val = value;
            sfx_k   = IDX_W'(order);
         end
         M_TRUNC_EXPG, M_TRUNC_EXPG_SGN: begin
            pfx_ones = at_cut ? cut_ext : mag;
            pfx_term = !at_cut;
            sfx_en   = at_cut;
            sfx_val  = over_cut;
            sfx_k    = IDX_W'(order);
            sign_en  = (method == M_TRUNC_EXPG_SGN) && (mag != '0);
            sign_bit = neg;
         end
         default: ;
      endcase
   end

   assign empty = (pfx_ones == '0) && !pfx_term && !sfx_en && !sign_en && (fix_cnt == '0);

endmodule

// File: rtl/se_bin_expg_step.sv
module se_bin_expg_step #(
   parameter int VAL_W = 16,
   parameter int IDX_W = 6
) (
   input  logic [VAL_W-1:0] rem,
   input  logic [IDX_W-1:0] kk,
   output logic             take,
   output logic [VAL_W-1:0] rem_nx
);

   localparam int W1 = VAL_W + 1;

   logic [W1-1:0] step;

   assign step   = W1'(1) << kk;
   assign take   = ({1'b0, rem} >= step);
   assign rem_nx = rem - step[VAL_W-1:0];

endmodule

// File: rtl/se_bin_seq.sv
module se_bin_seq
   import se_bin_pkg::*;
#(
   parameter int VAL_W = 16,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VAL_W-1:0] pfx_ones,
   input  logic             pfx_term,
   input  logic             sfx_en,
   input  logic [VAL_W-1:0] sfx_val,
   input  logic [IDX_W-1:0] sfx_k,
   input  logic             sign_en,
   input  logic             sign_bit,
   input  logic             fix_en,
   input  logic [IDX_W-1:0] fix_cnt,
   input  logic             empty,
   output logic             bin_valid,
   output logic             bin_bit,
   output logic             bin_last
);

   phase_e           ph_q, ph_d;
   logic [VAL_W-1:0] ones_q, ones_d;
   logic [VAL_W-1:0] rem_q, rem_d;
   logic [IDX_W-1:0] kk_q, kk_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             term_q, term_d;
   logic             sfx_q, sfx_d;
   logic             sgn_en_q, sgn_en_d;
   logic             sgn_q, sgn_d;
   logic             eg_take;
   logic [VAL_W-1:0] eg_rem;
   logic             pick;
   logic             bit_c;

   se_bin_expg_step #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_step (
      .rem    (rem_q),
      .kk     (kk_q),
      .take   (eg_take),
      .rem_nx (eg_rem)
   );

   // bit of the remainder addressed by idx (idx counts from 1)
   always_comb begin
      pick = 1'b0;
      for (int i = 0; i < VAL_W; i++) begin
         if (IDX_W'(i + 1) == idx_q) pick = rem_q[i];
      end
   end

   always_comb begin
      ph_d     = ph_q;
      ones_d   = ones_q;
      rem_d    = rem_q;
      kk_d     = kk_q;
      idx_d    = idx_q;
      term_d   = term_q;
      sfx_d    = sfx_q;
      sgn_en_d = sgn_en_q;
      sgn_d    = sgn_q;
      bit_c    = 1'b0;
      case (ph_q)
         PH_IDLE: begin
            if (start && !empty) begin
               ones_d   = pfx_ones;
               term_d   = pfx_term;
               sfx_d    = sfx_en;
               sgn_en_d = sign_en;
               sgn_d    = sign_bit;
               kk_d     = sfx_k;
               rem_d    = sfx_val;
               idx_d    = fix_cnt;
               if (fix_en)               ph_d = PH_FIX;
               else if (pfx_ones != '0)  ph_d = PH_ONES;
               else                      ph_d = after_ones(pfx_term, sfx_en, sign_en);
            end
         end
         PH_ONES: begin
            bit_c  = 1'b1;
            ones_d = ones_q - VAL_W'(1);
            if (ones_q == VAL_W'(1)) ph_d = after_ones(term_q, sfx_q, sgn_en_q);
         end
         PH_TERM: begin
            bit_c = 1'b0;
            ph_d  = after_term(sfx_q, sgn_en_q);
         end
         PH_EGPFX: begin
            bit_c = eg_take;
            if (eg_take) begin
               rem_d = eg_rem;
               kk_d  = kk_q + IDX_W'(1);
            end else if (kk_q != '0) begin
               idx_d = kk_q;
               ph_d  = PH_EGBIT;
            end else begin
               ph_d  = after_eg(sgn_en_q);
            end
         end
         PH_EGBIT: begin
            bit_c = pick;
            idx_d = idx_q - IDX_W'(1);
            if (idx_q == IDX_W'(1)) ph_d = after_eg(sgn_en_q);
         end
         PH_FIX: begin
            bit_c = pick;
            idx_d = idx_q - IDX_W'(1);
            if (idx_q == IDX_W'(1)) ph_d = PH_IDLE;
         end
         PH_SIGN: begin
            bit_c = sgn_q;
            ph_d  = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         ones_q   <= '0;
         rem_q    <= '0;
         kk_q     <= '0;
         idx_q    <= '0;
         term_q   <= 1'b0;
         sfx_q    <= 1'b0;
         sgn_en_q <= 1'b0;
         sgn_q    <= 1'b0;
      end else begin
         ph_q     <= ph_d;
         ones_q   <= ones_d;
         rem_q    <= rem_d;
         kk_q     <= kk_d;
         idx_q    <= idx_d;
         term_q   <= term_d;
         sfx_q    <= sfx_d;
         sgn_en_q <= sgn_en_d;
         sgn_q    <= sgn_d;
      end
   end

   assign bin_valid = (ph_q != PH_IDLE);
   assign bin_bit   = bit_c;
   assign bin_last  = bin_valid && (ph_d == PH_IDLE);

endmodule

// File: rtl/se_binarizer.sv
module se_binarizer #(
   parameter int VAL_W     = 16,
   parameter int CUT_W     = 5,
   parameter int K_W       = 3,
   parameter int LEN_W     = 5,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       method,
   input  logic [VAL_W-1:0] value,
   input  logic [CUT_W-1:0] cutoff,
   input  logic [K_W-1:0]   order,
   input  logic [LEN_W-1:0] fix_len,
   output logic             bin_valid,
   output logic             bin_bit,
   output logic             bin_last
);

   localparam int IDX_W = $clog2(VAL_W + (1 << K_W)) + 1;

   generate
      if (VAL_W < 2) begin : g_bad_val
         initial $fatal(1, "se_binarizer: VAL_W must be at least 2");
      end
      if (CUT_W > VAL_W) begin : g_bad_cut
         initial $fatal(1, "se_binarizer: CUT_W must not exceed VAL_W");
      end
      if (((1 << K_W) - 1) > VAL_W) begin : g_bad_k
         initial $fatal(1, "se_binarizer: largest order must not exceed VAL_W");
      end
      if (((1 << LEN_W) - 1) < VAL_W) begin : g_bad_len
         initial $fatal(1, "se_binarizer: LEN_W too narrow to express VAL_W");
      end
   endgenerate

   logic [VAL_W-1:0] pfx_ones;
   logic             pfx_term;
   logic             sfx_en;
   logic [VAL_W-1:0] sfx_val;
   logic [IDX_W-1:0] sfx_k;
   logic             sign_en;
   logic             sign_bit;
   logic             fix_en;
   logic [IDX_W-1:0] fix_cnt;
   logic             empty;

   se_bin_front #(
      .VAL_W(VAL_W), .CUT_W(CUT_W), .K_W(K_W), .LEN_W(LEN_W),
      .IDX_W(IDX_W), .SIGNED_EN(SIGNED_EN)
   ) u_front (
      .method   (method),
      .value    (value),
      .cutoff   (cutoff),
      .order    (order),
      .fix_len  (fix_len),
      .pfx_ones (pfx_ones),
      .pfx_term (pfx_term),
      .sfx_en   (sfx_en),
      .sfx_val  (sfx_val),
      .sfx_k    (sfx_k),
      .sign_en  (sign_en),
      .sign_bit (sign_bit),
      .fix_en   (fix_en),
      .fix_cnt  (fix_cnt),
      .empty    (empty)
   );

   se_bin_seq #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .pfx_ones  (pfx_ones),
      .pfx_term  (pfx_term),
      .sfx_en    (sfx_en),
      .sfx_val   (sfx_val),
      .sfx_k     (sfx_k),
      .sign_en   (sign_en),
      .sign_bit  (sign_bit),
      .fix_en    (fix_en),
      .fix_cnt   (fix_cnt),
      .empty     (empty),
      .bin_valid (bin_valid),
      .bin_bit   (bin_bit),
      .bin_last  (bin_last)
   );

endmodule

// File: rtl/se_binarizer_chk.sv
module se_binarizer_chk #(
   parameter int VAL_W = 16,
   parameter int CUT_W = 5,
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [2:0]       method,
   input logic [CUT_W-1:0] cutoff,
   input logic [LEN_W-1:0] fix_len,
   input logic             bin_valid,
   input logic             bin_bit,
   input logic             bin_last
);

   localparam int NB_W = VAL_W + 2;

   logic             accept;
   logic [2:0]       cap_m;
   logic [CUT_W-1:0] cap_c;
   logic [NB_W-1:0]  nbin;

   assign accept = start && !bin_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_m <= 3'd7;
         cap_c <= '0;
         nbin  <= '0;
      end else if (accept) begin
         cap_m <= method;
         cap_c <= cutoff;
         nbin  <= '0;
      end else if (bin_valid) begin
         nbin  <= nbin + NB_W'(1);
      end
   end

   // R1: unary strings are ones closed by one zero
   p_unary_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_valid && !bin_last && cap_m == 3'd0) |-> bin_bit);
   p_unary_term_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_valid && bin_last && cap_m == 3'd0) |-> !bin_bit);

   // R2: truncated unary never runs beyond the cutoff
   p_trunc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_valid && cap_m == 3'd1) |-> (nbin < NB_W'(cap_c)));

   // R7: framing of the bin stream
   p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bin_last |-> bin_valid);
   p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bin_last |=> !bin_valid);
   p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_valid && !bin_last) |=> bin_valid);
   p_open_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bin_valid) |-> $past(start));

   // R8: a start during the final bin launches nothing
   p_start_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_last && start) |=> !bin_valid);

   // R9: reserved codes and zero-length fixed fields stay idle
   p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && method >= 3'd6) |=> !bin_valid);
   p_fixed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && method == 3'd2 && fix_len == '0) |=> !bin_valid);

endmodule

bind se_binarizer se_binarizer_chk #(.VAL_W(VAL_W), .CUT_W(CUT_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .method    (method),
   .cutoff    (cutoff),
   .fix_len   (fix_len),
   .bin_valid (bin_valid),
   .bin_bit   (bin_bit),
   .bin_last  (bin_last)
);

// File: tb/se_binarizer_tb.sv
module se_binarizer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  method = '0;
   logic [15:0] value = '0;
   logic [4:0]  cutoff = '0;
   logic [2:0]  order = '0;
   logic [4:0]  fix_len = '0;
   logic        bin_valid, bin_bit, bin_last;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   se_binarizer u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .method(method), .value(value),
      .cutoff(cutoff), .order(order), .fix_len(fix_len),
      .bin_valid(bin_valid), .bin_bit(bin_bit), .bin_last(bin_last)
   );

   typedef struct packed {
      logic [2:0]  m;
      logic [15:0] v;
      logic [4:0]  c;
      logic [2:0]  k;
      logic [4:0]  l;
      logic [6:0]  n;
      logic [63:0] bits;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'd3,     5'd0,  3'd0, 5'd0,  7'd4,  64'hE,           4'd1}, // R1 unary 3
      '{3'd0, 16'd0,     5'd0,  3'd0, 5'd0,  7'd1,  64'h0,           4'd1}, // R1 unary 0
      '{3'd0, 16'd40,    5'd0,  3'd0, 5'd0,  7'd41, 64'h1FFFFFFFFFE, 4'd1}, // R1 long unary
      '{3'd1, 16'd5,     5'd3,  3'd0, 5'd0,  7'd3,  64'h7,           4'd2}, // R2 above cutoff
      '{3'd1, 16'd2,     5'd3,  3'd0, 5'd0,  7'd3,  64'h6,           4'd2}, // R2 below cutoff
      '{3'd1, 16'd3,     5'd3,  3'd0, 5'd0,  7'd3,  64'h7,           4'd2}, // R2 at cutoff
      '{3'd2, 16'd6,     5'd0,  3'd0, 5'd3,  7'd3,  64'h6,           4'd3}, // R3 three bits
      '{3'd2, 16'h00A5,  5'd0,  3'd0, 5'd8,  7'd8,  64'hA5,          4'd3}, // R3 byte
      '{3'd2, 16'h8001,  5'd0,  3'd0, 5'd20, 7'd16, 64'h8001,        4'd3}, // R3 length clamp
      '{3'd3, 16'd0,     5'd0,  3'd0, 5'd0,  7'd1,  64'h0,           4'd4}, // R4 EG0 of 0
      '{3'd3, 16'd3,     5'd0,  3'd0, 5'd0,  7'd5,  64'h18,          4'd4}, // R4 EG0 of 3
      '{3'd3, 16'd5,     5'd0,  3'd3, 5'd0,  7'd4,  64'h5,           4'd4}, // R4 EG3 of 5
      '{3'd3, 16'd10,    5'd0,  3'd1, 5'd0,  7'd6,  64'h34,          4'd4}, // R4 EG1 of 10
      '{3'd4, 16'd4,     5'd9,  3'd3, 5'd0,  7'd5,  64'h1E,          4'd5}, // R5 below cutoff
      '{3'd4, 16'd9,     5'd9,  3'd3, 5'd0,  7'd13, 64'h1FF0,        4'd5}, // R5 at cutoff
      '{3'd4, 16'd20,    5'd14, 3'd0, 5'd0,  7'd19, 64'h7FFFB,       4'd5}, // R5 level form
      '{3'd4, 16'd3,     5'd0,  3'd0, 5'd0,  7'd5,  64'h18,          4'd5}, // R5 cutoff 0
      '{3'd5, 16'hFFFD,  5'd9,  3'd3, 5'd0,  7'd5,  64'h1D,          4'd6}, // R6 minus 3
      '{3'd5, 16'd2,     5'd9,  3'd3, 5'd0,  7'd4,  64'hC,           4'd6}, // R6 plus 2
      '{3'd5, 16'd0,     5'd9,  3'd3, 5'd0,  7'd1,  64'h0,           4'd6}, // R6 zero, no sign
      '{3'd5, 16'hFFF4,  5'd9,  3'd3, 5'd0,  7'd14, 64'h3FE7,        4'd6}  // R6 minus 12
   };

   task automatic report_done();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // one request; gathers the string; gap flags any framing break (R7)
   task automatic run_case(input logic [2:0] m, input logic [15:0] v, input logic [4:0] c,
                           input logic [2:0] k, input logic [4:0] l,
                           output int n, output logic [63:0] bits, output bit gap);
      bit done;
      @(negedge clk);
      method = m; value = v; cutoff = c; order = k; fix_len = l; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0; bits = '0; gap = 1'b0; done = 1'b0;
      for (int i = 0; i < 200 && !done; i++) begin
         if (!bin_valid) begin
            gap  = 1'b1;
            done = 1'b1;
         end else begin
            bits = {bits[62:0], bin_bit};
            n++;
            if (bin_last) done = 1'b1;
            @(negedge clk);
         end
      end
      if (bin_valid || bin_last) gap = 1'b1;
   endtask

   task automatic check_idle(input logic [2:0] m, input logic [15:0] v, input logic [4:0] c,
                             input logic [4:0] l, input string what);
      bit seen;
      @(negedge clk);
      method = m; value = v; cutoff = c; order = '0; fix_len = l; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (bin_valid || bin_last) seen = 1'b1;
         @(negedge clk);
      end
      n_tests++;
      if (seen) begin
         n_fail++;
         $display("FAIL R9 %s: bins seen=1 expected 0", what);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report_done();
   end

   initial begin
      int          n;
      logic [63:0] got;
      bit          gap;

      // R10: reset state
      repeat (3) @(negedge clk);
      n_tests++;
      if (bin_valid || bin_last) begin
         n_fail++;
         $display("FAIL R10 in reset: valid=%0b last=%0b expected 0 0", bin_valid, bin_last);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_tests++;
      if (bin_valid || bin_last) begin
         n_fail++;
         $display("FAIL R10 after reset: valid=%0b last=%0b expected 0 0", bin_valid, bin_last);
      end

      // table walk (R1..R6, framing per R7 on every entry, back to back)
      for (int t = 0; t < NV; t++) begin
         run_case(VECS[t].m, VECS[t].v, VECS[t].c, VECS[t].k, VECS[t].l, n, got, gap);
         n_tests++;
         if (gap || n != int'(VECS[t].n) || got != VECS[t].bits) begin
            n_fail++;
            $display("FAIL R%0d vec %0d: n=%0d bits=%h framing_err=%0b expected n=%0d bits=%h framing_err=0",
                     VECS[t].req, t, n, got, gap, VECS[t].n, VECS[t].bits);
         end
      end

      // R8: start held high through a whole unary string, then released
      @(negedge clk);
      method = 3'd0; value = 16'd5; cutoff = '0; order = '0; fix_len = '0; start = 1'b1;
      @(negedge clk);
      method = 3'd2; value = 16'd3; fix_len = 5'd2;
      n = 0; got = '0; gap = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (bin_valid) begin
            got = {got[62:0], bin_bit};
            n++;
         end
         @(negedge clk);
         if (n > 0 && !bin_valid) break;
      end
      start = 1'b0;
      n_tests++;
      if (n != 6 || got != 64'h3E) begin
         n_fail++;
         $display("FAIL R8 held start: n=%0d bits=%h expected n=6 bits=3e", n, got);
      end
      @(negedge clk);
      n_tests++;
      if (bin_valid) begin
         n_fail++;
         $display("FAIL R8 after string: valid=%0b expected 0", bin_valid);
      end

      // R9: empty strings and reserved codes
      check_idle(3'd2, 16'hFFFF, 5'd0, 5'd0, "fixed length 0");
      check_idle(3'd1, 16'd5,    5'd0, 5'd0, "truncated unary cutoff 0");
      check_idle(3'd6, 16'd5,    5'd3, 5'd4, "method 6");
      check_idle(3'd7, 16'd5,    5'd3, 5'd4, "method 7");

      // R7: normal request straight after idle cases still framed correctly
      run_case(3'd1, 16'd1, 5'd4, 3'd0, 5'd0, n, got, gap);
      n_tests++;
      if (gap || n != 2 || got != 64'h2) begin
         n_fail++;
         $display("FAIL R7 follow-up: n=%0d bits=%h framing_err=%0b expected n=2 bits=2 framing_err=0",
                  n, got, gap);
      end

      report_done();
   end

endmodule